// File: doc/BRIEF.md
# Prescaled PWM Down-Counter Channel

This block is a single pulse-width-modulation timer channel. The system clock passes through an 8-bit prescaler and then a selectable divider. Together they produce a one-cycle tick enable. Each tick steps a 16-bit down counter. A period value sets how far the counter starts from, and a compare value sets the duty. The pin signal is high while the count is above the compare value. Period and compare are held in shadow copies: a write changes the programmed value at once, but the running counter only picks it up when a new PWM cycle starts.

Software drives the channel through a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational. A run bit starts and stops the channel. A mode bit picks one-shot or auto-reload. Three more bits control inversion, gating of the pin and the interrupt. A sticky flag records each time the counter finishes a PWM cycle at zero, and software clears it by writing 1. The whole block uses one clock domain and a synchronous active-low reset.

Register map (word addresses on `reg_addr`):
- Address 0: prescale value in bits [7:0].
- Address 1: divider select in bits [2:0].
- Address 2: control bits.
  - bit0: run.
  - bit1: invert.
  - bit2: mode (1 = auto-reload, 0 = one-shot).
  - bit3: pin enable.
  - bit4: interrupt enable.
- Address 3: period in bits [15:0].
- Address 4: compare in bits [15:0].
- Address 5: live count, read-only.
- Address 6: flag in bit0, write 1 to clear.

Top module: `pwm_dc_chan`

## Requirements
- R1: After reset the count, pin output and interrupt are 0, and every register at addresses 0 to 6 reads 0.
- R2: While running, the count steps down by one once every (P+1)*D clock cycles, where P is the prescale value at address 0 and D is the divide ratio from R3. The first step comes (P+1)*D cycles after the load edge.
- R3: Divider select codes at address 1 give these ratios: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /16 and 4 gives /1. Codes 5 to 7 also give /1.
- R4: On the clock edge after the run bit (address 2, bit0) goes from 0 to 1, the counter loads the programmed period. The live count is visible both on `count_val` and at read address 5.
- R5: In auto-reload mode (address 2, bit2 = 1), a tick that arrives with the count at 0 reloads the counter from the programmed period, so one PWM cycle lasts period+1 ticks.
- R6: In one-shot mode (bit2 = 0), a tick that arrives with the count at 0 stops the channel. The count stays at 0 until the run bit is cleared and set again.
- R7: The period and compare values are written to the register at once, but the running counter only uses them at the next start or reload. A compare write in the middle of a cycle does not change the pin output in that cycle.
- R8: The raw output is 1 while the channel runs and the count is greater than the active compare value. The invert bit (bit1) inverts the raw output. The pin enable bit (bit3) forces `pwm_out` to 0 when it is clear.
- R9: A tick that arrives with the count at 0 sets the flag only when the interrupt enable bit (bit4) is 1. Writing 1 to bit0 of address 6 clears the flag, and `irq` follows the flag.
- R10: A control write that changes the mode bit clears both the programmed period and the programmed compare value to 0. A control write that leaves the mode bit unchanged does not touch them.
- R11: Clearing the run bit stops the counter. The count holds its value, and with the inverter off the pin output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for `reg_addr` |
| pwm_out | output | 1 | PWM pin signal after inversion and gating |
| count_val | output | 16 | Live down-counter value |
| irq | output | 1 | Zero-reached interrupt flag |

## Verification
The bench checks several corner cases, each chosen to expose a specific design error:
- Tick cadence at three prescale/divider combinations. Checks sit one cycle before and one cycle on the expected step, so an off-by-one prescaler or a wrong divide table shifts the step by a cycle and is caught.
- A compare write and a period write made in the middle of a cycle. A design without shadowing would change the pin level or the reload value early.
- The one-shot end. A design that reloads there would leave the count non-zero.
- A mode toggle. A design that fails to clear the programmed values on a mode change would show the old period on read-back.
- Interrupt behaviour. The flag must stay low with the interrupt disabled, and the clear-by-writing-1 must work; a wrong implementation of either is caught.

// File: rtl/pwm_dc_pkg.sv
// Package: shared constants, control-word layout and divider decode for the
// prescaled PWM down-counter channel.
// Assumes: a 3-bit divider select field and a word-addressed register port.
package pwm_dc_pkg;

    // Register word addresses
    localparam int A_PSC = 0;   // prescale value
    localparam int A_DIV = 1;   // divider select
    localparam int A_CTL = 2;   // control word
    localparam int A_PER = 3;   // programmed period
    localparam int A_CMP = 4;   // programmed compare
    localparam int A_CNT = 5;   // live count (read-only)
    localparam int A_FLG = 6;   // zero flag (write 1 to clear)

    // Divider select field width and divider counter width (max ratio 16)
    localparam int DSEL_W = 3;
    localparam int DIVC_W = 4;

    // Control word, bit0 = run ... bit4 = interrupt enable
    typedef struct packed {
        logic irq_en;
        logic out_en;
        logic auto_rl;
        logic invert;
        logic run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Terminal value of the divider counter (ratio minus one) for a select code
    function automatic logic [DIVC_W-1:0] div_last_f(input logic [DSEL_W-1:0] sel);
        case (sel)
            3'd0:    div_last_f = 4'd1;   // /2
            3'd1:    div_last_f = 4'd3;   // /4
            3'd2:    div_last_f = 4'd7;   // /8
            3'd3:    div_last_f = 4'd15;  // /16
            default: div_last_f = 4'd0;   // /1 (code 4 and spare codes)
        endcase
    endfunction

endpackage

// File: rtl/pwm_dc_regs.sv
// Module: pwm_dc_regs
// Holds the software-visible registers of the channel, the sticky zero flag
// and the combinational read multiplexer. A control write that flips the
// mode bit clears the programmed period and compare values.
// Assumes: one write per cycle, reads have no side effects.
module pwm_dc_regs
    import pwm_dc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt_live,
    input  logic              zero_evt,
    output logic [PSC_W-1:0]  psc_q,
    output logic [DSEL_W-1:0] dsel_q,
    output ctl_t              ctl_q,
    output logic [CNT_W-1:0]  per_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              flag_q,
    output logic              flag_clr
);

    ctl_t ctl_wr;
    logic hit_psc, hit_div, hit_ctl, hit_per, hit_cmp, hit_flg;
    logic unused_wr_hi;

    // Address decode for the write strobe
    always_comb begin
        hit_psc = wr_en && (addr == ADDR_W'(A_PSC));
        hit_div = wr_en && (addr == ADDR_W'(A_DIV));
        hit_ctl = wr_en && (addr == ADDR_W'(A_CTL));
        hit_per = wr_en && (addr == ADDR_W'(A_PER));
        hit_cmp = wr_en && (addr == ADDR_W'(A_CMP));
        hit_flg = wr_en && (addr == ADDR_W'(A_FLG));
    end

    assign ctl_wr       = ctl_t'(wr_data[CTL_W-1:0]);
    assign flag_clr     = hit_flg && wr_data[0];
    assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    // Prescale and divider select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            dsel_q <= '0;
        end else begin
            if (hit_psc) psc_q  <= wr_data[PSC_W-1:0];
            if (hit_div) dsel_q <= wr_data[DSEL_W-1:0];
        end
    end

    // Control, period and compare registers; a mode flip clears period/compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            per_q <= '0;
            cmp_q <= '0;
        end else if (hit_ctl) begin
            ctl_q <= ctl_wr;
            if (ctl_wr.auto_rl != ctl_q.auto_rl) begin
                per_q <= '0;
                cmp_q <= '0;
            end
        end else begin
            if (hit_per) per_q <= wr_data[CNT_W-1:0];
            if (hit_cmp) cmp_q <= wr_data[CNT_W-1:0];
        end
    end

    // Sticky zero flag: a new event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (zero_evt && ctl_q.irq_en) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Combinational read multiplexer
    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(A_PSC): rd_data = DATA_W'(psc_q);
            ADDR_W'(A_DIV): rd_data = DATA_W'(dsel_q);
            ADDR_W'(A_CTL): rd_data = DATA_W'(ctl_q);
            ADDR_W'(A_PER): rd_data = DATA_W'(per_q);
            ADDR_W'(A_CMP): rd_data = DATA_W'(cmp_q);
            ADDR_W'(A_CNT): rd_data = DATA_W'(cnt_live);
            ADDR_W'(A_FLG): rd_data = DATA_W'(flag_q);
            default:        rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_dc_tick.sv
// Module: pwm_dc_tick
// Produces a single-cycle tick enable every (psc+1)*ratio clock cycles. The
// prescale stage counts system clocks and the divider stage counts prescale
// terminals. Both stages restart from zero while the enable is low.
// Assumes: the divider ratio is 1, 2, 4, 8 or 16 (see pwm_dc_pkg::div_last_f).
module pwm_dc_tick
    import pwm_dc_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSC_W-1:0]  psc,
    input  logic [DSEL_W-1:0] dsel,
    output logic              tick
);

    logic [PSC_W-1:0]  psc_cnt;
    logic [DIVC_W-1:0] div_cnt;
    logic [DIVC_W-1:0] div_last;
    logic              psc_hit;
    logic              div_hit;

    assign div_last = div_last_f(dsel);
    assign psc_hit  = (psc_cnt == psc);
    assign div_hit  = (div_cnt >= div_last);
    assign tick     = en && psc_hit && div_hit;

    // Prescale counter: wraps at the programmed value
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            psc_cnt <= '0;
        end else if (psc_hit) begin
            psc_cnt <= '0;
        end else begin
            psc_cnt <= psc_cnt + 1'b1;
        end
    end

    // Divider counter: advances once per prescale terminal
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
        end else if (psc_hit) begin
            if (div_hit) div_cnt <= '0;
            else         div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_dc_counter.sv
// Module: pwm_dc_counter
// The down counter with its shadowed compare. A rising run bit loads the
// programmed period and compare. A tick that arrives with the count at zero
// either reloads both shadows (auto-reload) or stops the channel (one-shot).
// A low run bit stops the channel and freezes the count.
// Assumes: tick is only asserted while live and run are both high.
module pwm_dc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             auto_rl,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_cmp,
    output logic             live,
    output logic             zero_evt
);

    logic run_q;
    logic start;

    assign start    = run && !run_q;
    assign zero_evt = live && tick && (cnt == '0);

    // Run-edge detector
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Count, active compare and live state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_cmp <= '0;
            live    <= 1'b0;
        end else if (!run) begin
            live <= 1'b0;
        end else if (start) begin
            cnt     <= per;
            act_cmp <= cmp;
            live    <= 1'b1;
        end else if (live && tick) begin
            if (cnt == '0) begin
                if (auto_rl) begin
                    cnt     <= per;
                    act_cmp <= cmp;
                end else begin
                    live <= 1'b0;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_dc_chan.sv
// Module: pwm_dc_chan (top)
// One prescaled PWM down-counter channel: registers, tick generator, down
// counter and output stage. The output is high while the count exceeds the
// active compare, then passes through the inverter and the pin gate.
// Assumes: a single clock domain; reset is synchronous and active low.
module pwm_dc_chan
    import pwm_dc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              pwm_out,
    output logic [CNT_W-1:0]  count_val,
    output logic              irq
);

    logic [PSC_W-1:0]  psc_q;
    logic [DSEL_W-1:0] dsel_q;
    ctl_t              ctl_q;
    logic [CNT_W-1:0]  per_q, cmp_q;
    logic [CNT_W-1:0]  cnt, act_cmp;
    logic              live, zero_evt, tick, flag_q, flag_clr;
    logic              pwm_raw;
    logic              irq_en_w, mode_w;

    assign irq_en_w = ctl_q.irq_en;
    assign mode_w   = ctl_q.auto_rl;

    pwm_dc_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en),
        .wr_data(reg_wr_data), .rd_data(reg_rd_data), .cnt_live(cnt),
        .zero_evt(zero_evt), .psc_q(psc_q), .dsel_q(dsel_q), .ctl_q(ctl_q),
        .per_q(per_q), .cmp_q(cmp_q), .flag_q(flag_q), .flag_clr(flag_clr)
    );

    pwm_dc_tick #(.PSC_W(PSC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(live && ctl_q.run),
        .psc(psc_q), .dsel(dsel_q), .tick(tick)
    );

    pwm_dc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .auto_rl(ctl_q.auto_rl),
        .tick(tick), .per(per_q), .cmp(cmp_q), .cnt(cnt), .act_cmp(act_cmp),
        .live(live), .zero_evt(zero_evt)
    );

    // Output stage: compare, invert, gate
    always_comb begin
        pwm_raw = live && (cnt > act_cmp);
        pwm_out = ctl_q.out_en && (pwm_raw ^ ctl_q.invert);
    end

    assign count_val = cnt;
    assign irq       = flag_q;

endmodule

// File: rtl/pwm_dc_chan_chk.sv
// Module: pwm_dc_chan_chk
// Property checker bound to pwm_dc_chan. It watches the counter, the shadow
// compare, the mode bit and the flag across cycles.
module pwm_dc_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             live,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] act_cmp,
    input logic [CNT_W-1:0] per_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             zero_evt,
    input logic             irq_en,
    input logic             mode,
    input logic             irq,
    input logic             flag_clr
);

    // R1: reset leaves a quiet channel
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (count_val == '0 && !irq && !live));

    // R2: while running and not at zero, the count holds or steps down by one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(live) && $past(count_val) != '0)
        |-> (count_val == $past(count_val) || count_val == $past(count_val) - 1'b1));

    // R11: a stopped channel keeps its count until it is started again
    a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (live || $stable(count_val)));

    // R7: the active compare only changes at a start or a reload
    a_r7_shadow_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(live) && !$past(zero_evt)) |-> $stable(act_cmp));

    // R10: a mode flip leaves period and compare cleared
    a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> (per_q == '0 && cmp_q == '0));

    // R9: the flag rises only after an enabled zero event
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(zero_evt && irq_en));

    // R9: the flag stays set until cleared
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_clr) |=> irq);

endmodule

bind pwm_dc_chan pwm_dc_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .live(live), .count_val(count_val),
    .act_cmp(act_cmp), .per_q(per_q), .cmp_q(cmp_q), .zero_evt(zero_evt),
    .irq_en(irq_en_w), .mode(mode_w), .irq(irq), .flag_clr(flag_clr)
);

// File: tb/pwm_dc_chan_tb_top.sv
// Scoreboard bench for pwm_dc_chan: the driver pushes per-cycle expectations,
// the monitor pops and compares them at the falling clock edge.
module pwm_dc_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        pwm_out;
    logic [15:0] count_val;
    logic        irq;

    always #5 clk = ~clk;

    pwm_dc_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .pwm_out(pwm_out), .count_val(count_val), .irq(irq)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned cyc;
        int          cnt;
        bit          pwm;
        bit          irq;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic push(input int unsigned c, input int cnt, input bit p,
                        input bit i, input string tag);
        exp_t e;
        e.cyc = c; e.cnt = cnt; e.pwm = p; e.irq = i; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare queued expectations against the ports
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (e.cyc != cyc || count_val != 16'(e.cnt) ||
                    pwm_out !== e.pwm || irq !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s at cycle %0d (due %0d): got cnt=%0d pwm=%0b irq=%0b, expected cnt=%0d pwm=%0b irq=%0b",
                             e.tag, cyc, e.cyc, count_val, pwm_out, irq,
                             e.cnt, e.pwm, e.irq);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr    = a;
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp,
                          input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s read addr %0d: got %0h, expected %0h",
                     tag, a, reg_rd_data, exp);
        end
    endtask

    task automatic wait_until(input int unsigned n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Control word values: bit0 run, bit1 invert, bit2 auto, bit3 pin, bit4 irq
    initial begin
        int unsigned l, s, e;
        int          v;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state of ports and registers
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 32'd0, "R1");
        push(cyc + 1, 0, 1'b0, 1'b0, "R1");
        wait_until(cyc + 2);

        // Auto-reload, prescale 1, divide /1 -> one step every 2 cycles
        wr(3'd2, 32'd4);
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd4);
        wr(3'd3, 32'd5);
        wr(3'd4, 32'd2);
        wr(3'd2, 32'd29);
        l = cyc + 1;
        push(l,      5, 1'b1, 1'b0, "R4");
        push(l + 1,  5, 1'b1, 1'b0, "R2");
        push(l + 2,  4, 1'b1, 1'b0, "R2");
        push(l + 4,  3, 1'b1, 1'b0, "R7");
        push(l + 6,  2, 1'b0, 1'b0, "R8");
        push(l + 10, 0, 1'b0, 1'b0, "R2");
        push(l + 11, 0, 1'b0, 1'b0, "R9");
        push(l + 12, 3, 1'b0, 1'b1, "R5");
        push(l + 14, 2, 1'b0, 1'b1, "R7");
        push(l + 16, 1, 1'b0, 1'b0, "R9");
        push(l + 18, 0, 1'b0, 1'b0, "R5");
        push(l + 20, 3, 1'b0, 1'b1, "R9");
        wait_until(l + 2);
        wr(3'd4, 32'd4);          // compare change mid-cycle (edge l+3)
        wr(3'd3, 32'd3);          // period change mid-cycle (edge l+4)
        wait_until(l + 14);
        wr(3'd6, 32'd1);          // clear flag (edge l+15)
        wait_until(l + 20);
        rd_chk(3'd5, 32'd3, "R4");

        // R11: stop holds the count
        wr(3'd2, 32'd28);
        s = cyc;
        v = 3 - int'((s - (l + 20)) / 2);
        push(s + 1,  v, 1'b0, 1'b1, "R11");
        push(s + 10, v, 1'b0, 1'b1, "R11");
        wait_until(s + 10);

        // R10: mode flip clears period/compare, same mode keeps them
        wr(3'd2, 32'd0);
        rd_chk(3'd3, 32'd0, "R10");
        rd_chk(3'd4, 32'd0, "R10");
        wr(3'd3, 32'd9);
        wr(3'd2, 32'd8);
        rd_chk(3'd3, 32'd9, "R10");

        // R6: one-shot, prescale 0, divide /2
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd7);
        wr(3'd4, 32'd3);
        wr(3'd6, 32'd1);
        wr(3'd2, 32'd25);
        l = cyc + 1;
        push(l,      7, 1'b1, 1'b0, "R6");
        push(l + 1,  7, 1'b1, 1'b0, "R3");
        push(l + 2,  6, 1'b1, 1'b0, "R3");
        push(l + 8,  3, 1'b0, 1'b0, "R8");
        push(l + 14, 0, 1'b0, 1'b0, "R6");
        push(l + 15, 0, 1'b0, 1'b0, "R6");
        push(l + 16, 0, 1'b0, 1'b1, "R6");
        push(l + 40, 0, 1'b0, 1'b1, "R6");
        wait_until(l + 40);

        // R3: prescale 2, divide /16 -> 48 cycles per step
        wr(3'd2, 32'd8);
        wr(3'd6, 32'd1);
        wr(3'd0, 32'd2);
        wr(3'd1, 32'd3);
        wr(3'd3, 32'd4);
        wr(3'd4, 32'd0);
        wr(3'd2, 32'd25);
        l = cyc + 1;
        push(l,      4, 1'b1, 1'b0, "R3");
        push(l + 47, 4, 1'b1, 1'b0, "R3");
        push(l + 48, 3, 1'b1, 1'b0, "R3");
        wait_until(l + 48);

        // R3: spare code 7 acts as /1, one-shot end sets the flag
        wr(3'd2, 32'd8);
        wr(3'd1, 32'd7);
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd25);
        l = cyc + 1;
        push(l,     4, 1'b1, 1'b0, "R3");
        push(l + 1, 3, 1'b1, 1'b0, "R3");
        push(l + 4, 0, 1'b0, 1'b0, "R6");
        push(l + 5, 0, 1'b0, 1'b1, "R9");
        wait_until(l + 6);

        // R8/R9: pin gate off, then inverter on; interrupt disabled
        wr(3'd2, 32'd8);
        wr(3'd6, 32'd1);
        wr(3'd2, 32'd4);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd1);
        wr(3'd2, 32'd7);
        l = cyc + 1;
        push(l,     3, 1'b0, 1'b0, "R8");
        push(l + 1, 2, 1'b0, 1'b0, "R8");
        wait_until(l + 1);
        wr(3'd2, 32'd15);
        e = cyc;
        for (int unsigned c = e + 1; c <= e + 4; c++) begin
            v = 3 - int'((c - l) % 4);
            push(c, v, !(v > 1), 1'b0, "R8");
        end
        push(l + 8, 3, 1'b0, 1'b0, "R9");
        wait_until(l + 9);

        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 scoreboard: %0d expectations left, expected 0", sb_q.size());
        end
        done = 1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

endmodule